// File: doc/BRIEF.md
# Functional-Unit-Bound Register Rename Stage

This stage sits between instruction decode and dispatch in an out-of-order core. Each physical register is the output register of one functional unit in an ALU class, plus a bank of cold-storage entries owned by a move-only unit, one entry per architectural register. For every incoming micro-op the stage looks up its two source operands in the mapping table, picks a unit of the requested ALU class for the destination, updates the mapping and emits the renamed micro-op on a registered output.

When no unit of the class is free, the stage reclaims a unit that has finished computing. A reclaimed unit may still hold the only copy of an architectural register's value. In that case the stage first emits a copy micro-op that moves the value into that register's cold-storage entry, remaps the register there, and holds the original micro-op until every reader of the unit, including the copy, has captured its operand. Each physical register carries a pending-reader counter. The counter goes up once for every dispatched micro-op that names the register as a source, and it goes down when a reader reports capture. The stage stalls on busy units, on outstanding readers, and on a shortage of copy slots.

Top module: `rn_fu_rename`

## Requirements
- R1: Tags 0 to NU-1 name the ALU units in class order (class c owns tags c*UPC to c*UPC+UPC-1). Tag NU+a names the cold entry of architectural register a. After reset, architectural register a maps to tag NU+a, no unit is busy, and out_valid is low.
- R2: A renamed micro-op leaves one cycle after acceptance with out_is_copy low, out_dst_tag set to the chosen unit, and out_src0_tag/out_src1_tag set to the mappings that were current when it was accepted. The destination register is then remapped to the chosen unit.
- R3: A unit is free when it is not busy, no architectural register maps to it and it has no pending readers. The lowest-index free unit of the requested class is chosen first.
- R4: While every unit of the requested class is busy (dispatched and no unit_done yet), in_ready stays low.
- R5: If the chosen unit is mapped by architectural register a, and a differs from the destination or is one of the micro-op's sources, the stage emits a copy (out_is_copy high, out_dst_tag NU+a, both source tags equal to the unit, out_slot the lowest free copy slot) and remaps a to NU+a.
- R6: If the only register mapping the chosen unit is the destination itself and that register is not a source, no copy is emitted.
- R7: After a copy, the original micro-op is held (in_ready low) until the reclaimed unit has no pending readers. It then leaves in a later cycle on the same unit.
- R8: A copy needs a free copy slot. A slot stays taken from its copy until copy_done_valid names it, and while no slot is free the stage stalls.
- R9: When no unit of the class is free, the stage chooses, among the non-busy units, the one with the fewest pending readers, and ties go to the lowest index.
- R10: A dispatched micro-op raises the counter of each distinct source tag by one, even when both sources name the same tag. Each cycle in which rd_release bit t is high lowers counter t by one, stopping at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded micro-op present |
| in_ready | output | 1 | Micro-op accepted at this edge |
| in_cls | input | CW | Requested ALU class |
| in_dst | input | AW | Destination architectural register |
| in_src0 | input | AW | First source architectural register |
| in_src1 | input | AW | Second source architectural register |
| unit_done_valid | input | 1 | A unit has produced its result |
| unit_done_idx | input | UW | Index of that unit |
| copy_done_valid | input | 1 | A copy slot has finished |
| copy_done_slot | input | SW | Index of that slot |
| rd_release | input | NP | Per-tag operand-capture pulses |
| out_valid | output | 1 | Dispatch output valid |
| out_is_copy | output | 1 | Output is a copy micro-op |
| out_dst_tag | output | TAG_W | Destination physical tag |
| out_src0_tag | output | TAG_W | First source physical tag |
| out_src1_tag | output | TAG_W | Second source physical tag |
| out_slot | output | SW | Copy slot (zero for normal micro-ops) |

## Verification
The micro-op stream is built so that the chosen unit falls into each selection case in turn: a free unit, a reclaimable unit whose only mapper is the destination, one mapped by an unrelated register, and one whose owner is also read as a source. Each case tells a missing copy apart from a spurious one. A sequence with both sources naming the same unit, followed by exactly two capture pulses, separates counting once per micro-op from counting once per operand. A class with unequal reader counts separates fewest-readers selection from plain lowest-index selection. Holding copy slots busy, and holding readers outstanding on the reclaimed unit, checks that each of these stalls releases on exactly its own event.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic {OUT_OP = 1'b0, OUT_COPY = 1'b1} out_kind_e;

  function automatic int wbits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NARCH = 8,
  parameter int NU    = 6,
  parameter int TAG_W = 4,
  parameter int AW    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [AW-1:0]                   rd0_arch,
  input  logic [AW-1:0]                   rd1_arch,
  output logic [TAG_W-1:0]                rd0_tag,
  output logic [TAG_W-1:0]                rd1_tag,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   wr_arch,
  input  logic [TAG_W-1:0]                wr_tag,
  output logic [NARCH-1:0][TAG_W-1:0]     map_all
);
  logic [TAG_W-1:0] tbl [NARCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < NARCH; a++) tbl[a] <= TAG_W'(NU + a);
    end else if (wr_en) begin
      tbl[wr_arch] <= wr_tag;
    end
  end

  assign rd0_tag = tbl[rd0_arch];
  assign rd1_tag = tbl[rd1_arch];

  for (genvar a = 0; a < NARCH; a++) begin : g_view
    assign map_all[a] = tbl[a];
  end
endmodule

// File: rtl/rn_occupancy.sv
module rn_occupancy #(
  parameter int NARCH  = 8,
  parameter int NU     = 6,
  parameter int NP     = 14,
  parameter int TAG_W  = 4,
  parameter int AW     = 3,
  parameter int UW     = 3,
  parameter int PEND_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NARCH-1:0][TAG_W-1:0]   map_all,
  input  logic                          set_busy,
  input  logic [UW-1:0]                 set_idx,
  input  logic                          done_valid,
  input  logic [UW-1:0]                 done_idx,
  input  logic [NP-1:0]                 inc,
  input  logic [NP-1:0]                 dec,
  output logic [NU-1:0]                 busy,
  output logic [NU-1:0]                 mapped,
  output logic [NU-1:0][AW-1:0]         owner,
  output logic [NP-1:0][PEND_W-1:0]     pend
);
  // reverse lookup: which architectural register names each unit
  always_comb begin
    mapped = '0;
    owner  = '0;
    for (int a = 0; a < NARCH; a++) begin
      if (map_all[a] < TAG_W'(NU)) begin
        mapped[map_all[a][UW-1:0]] = 1'b1;
        owner[map_all[a][UW-1:0]]  = AW'(a);
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_busy
    always_ff @(posedge clk) begin
      if (rst) begin
        busy[u] <= 1'b0;
      end else if (set_busy && set_idx == UW'(u)) begin
        busy[u] <= 1'b1;
      end else if (done_valid && done_idx == UW'(u)) begin
        busy[u] <= 1'b0;
      end
    end
  end

  for (genvar t = 0; t < NP; t++) begin : g_pend
    logic take;
    assign take = dec[t] && (pend[t] != '0);
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[t] <= '0;
      end else begin
        pend[t] <= pend[t] + PEND_W'(inc[t]) - PEND_W'(take);
      end
    end
  end
endmodule

// File: rtl/rn_unit_pick.sv
module rn_unit_pick #(
  parameter int NCLS   = 2,
  parameter int UPC    = 3,
  parameter int NU     = 6,
  parameter int CW     = 1,
  parameter int UW     = 3,
  parameter int PEND_W = 3
) (
  input  logic [CW-1:0]               cls,
  input  logic [NU-1:0]               busy,
  input  logic [NU-1:0]               mapped,
  input  logic [NU-1:0][PEND_W-1:0]   unit_pend,
  output logic                        found,
  output logic [UW-1:0]               idx
);
  logic              free_hit;
  logic              idle_hit;
  logic [UW-1:0]     free_idx;
  logic [UW-1:0]     idle_idx;
  logic [PEND_W-1:0] best;

  always_comb begin
    free_hit = 1'b0;
    idle_hit = 1'b0;
    free_idx = '0;
    idle_idx = '0;
    best     = '0;
    for (int i = 0; i < UPC; i++) begin
      int u;
      u = int'(cls) * UPC + i;
      if (u < NU && int'(cls) < NCLS) begin
        if (!free_hit && !busy[u] && !mapped[u] && unit_pend[u] == '0) begin
          free_hit = 1'b1;
          free_idx = UW'(u);
        end
        if (!busy[u] && (!idle_hit || unit_pend[u] < best)) begin
          idle_hit = 1'b1;
          idle_idx = UW'(u);
          best     = unit_pend[u];
        end
      end
    end
    found = free_hit || idle_hit;
    idx   = free_hit ? free_idx : idle_idx;
  end
endmodule

// File: rtl/rn_slot_pool.sv
module rn_slot_pool #(
  parameter int NSLOT = 2,
  parameter int SW    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             release_valid,
  input  logic [SW-1:0]    release_slot,
  output logic             any_free,
  output logic [SW-1:0]    free_slot,
  output logic [NSLOT-1:0] slot_busy
);
  always_comb begin
    any_free  = 1'b0;
    free_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!slot_busy[i]) begin
        any_free  = 1'b1;
        free_slot = SW'(i);
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_busy[s] <= 1'b0;
      end else if (alloc && free_slot == SW'(s)) begin
        slot_busy[s] <= 1'b1;
      end else if (release_valid && release_slot == SW'(s)) begin
        slot_busy[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rn_fu_rename.sv
module rn_fu_rename #(
  parameter int NARCH  = 8,
  parameter int NCLS   = 2,
  parameter int UPC    = 3,
  parameter int NSLOT  = 2,
  parameter int PEND_W = 3,
  localparam int NU    = NCLS * UPC,
  localparam int NP    = NU + NARCH,
  localparam int TAG_W = rn_pkg::wbits(NP),
  localparam int AW    = rn_pkg::wbits(NARCH),
  localparam int CW    = rn_pkg::wbits(NCLS),
  localparam int UW    = rn_pkg::wbits(NU),
  localparam int SW    = rn_pkg::wbits(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW-1:0]    in_cls,
  input  logic [AW-1:0]    in_dst,
  input  logic [AW-1:0]    in_src0,
  input  logic [AW-1:0]    in_src1,
  input  logic             unit_done_valid,
  input  logic [UW-1:0]    unit_done_idx,
  input  logic             copy_done_valid,
  input  logic [SW-1:0]    copy_done_slot,
  input  logic [NP-1:0]    rd_release,
  output logic             out_valid,
  output logic             out_is_copy,
  output logic [TAG_W-1:0] out_dst_tag,
  output logic [TAG_W-1:0] out_src0_tag,
  output logic [TAG_W-1:0] out_src1_tag,
  output logic [SW-1:0]    out_slot
);
  import rn_pkg::*;

  logic [NARCH-1:0][TAG_W-1:0] map_all;
  logic [TAG_W-1:0]            s0_tag, s1_tag;
  logic [NU-1:0]               busy, mapped;
  logic [NU-1:0][AW-1:0]       owner;
  logic [NP-1:0][PEND_W-1:0]   pend;
  logic                        pick_ok;
  logic [UW-1:0]               pick_idx;
  logic                        slot_any;
  logic [SW-1:0]               slot_idx;
  logic [NSLOT-1:0]            slot_busy;

  logic          lock_q;
  logic [UW-1:0] lock_idx_q;
  logic          act_ok;
  logic [UW-1:0] act_idx;
  logic [AW-1:0] owner_a;
  logic [TAG_W-1:0] victim_tag, cold_tag;
  logic          need_copy, do_copy, do_op;
  logic          map_we;
  logic [AW-1:0] map_wa;
  logic [TAG_W-1:0] map_wt;
  logic [NP-1:0] inc_vec;

  out_kind_e        kind_q;
  logic             valid_q;
  logic [TAG_W-1:0] dst_q, src0_q, src1_q;
  logic [SW-1:0]    slot_q;

  rn_map_table #(.NARCH(NARCH), .NU(NU), .TAG_W(TAG_W), .AW(AW)) u_map (
    .clk(clk), .rst(rst),
    .rd0_arch(in_src0), .rd1_arch(in_src1),
    .rd0_tag(s0_tag), .rd1_tag(s1_tag),
    .wr_en(map_we), .wr_arch(map_wa), .wr_tag(map_wt),
    .map_all(map_all)
  );

  rn_occupancy #(.NARCH(NARCH), .NU(NU), .NP(NP), .TAG_W(TAG_W), .AW(AW),
                 .UW(UW), .PEND_W(PEND_W)) u_occ (
    .clk(clk), .rst(rst), .map_all(map_all),
    .set_busy(do_op), .set_idx(act_idx),
    .done_valid(unit_done_valid), .done_idx(unit_done_idx),
    .inc(inc_vec), .dec(rd_release),
    .busy(busy), .mapped(mapped), .owner(owner), .pend(pend)
  );

  rn_unit_pick #(.NCLS(NCLS), .UPC(UPC), .NU(NU), .CW(CW), .UW(UW),
                 .PEND_W(PEND_W)) u_pick (
    .cls(in_cls), .busy(busy), .mapped(mapped), .unit_pend(pend[NU-1:0]),
    .found(pick_ok), .idx(pick_idx)
  );

  rn_slot_pool #(.NSLOT(NSLOT), .SW(SW)) u_slots (
    .clk(clk), .rst(rst), .alloc(do_copy),
    .release_valid(copy_done_valid), .release_slot(copy_done_slot),
    .any_free(slot_any), .free_slot(slot_idx), .slot_busy(slot_busy)
  );

  // a unit emptied by a copy stays reserved for the held micro-op
  assign act_ok     = lock_q || pick_ok;
  assign act_idx    = lock_q ? lock_idx_q : pick_idx;
  assign owner_a    = owner[act_idx];
  assign victim_tag = TAG_W'(act_idx);
  assign cold_tag   = TAG_W'(NU) + TAG_W'(owner_a);

  assign need_copy = mapped[act_idx] &&
                     (owner_a != in_dst || owner_a == in_src0 || owner_a == in_src1);

  assign do_copy = in_valid && act_ok && need_copy && !busy[act_idx] && slot_any &&
                   (pend[cold_tag] == '0) && !(&pend[victim_tag]);

  assign do_op = in_valid && act_ok && !need_copy && !busy[act_idx] &&
                 (pend[victim_tag] == '0) &&
                 !(&pend[s0_tag]) && !(&pend[s1_tag]);

  assign in_ready = do_op;

  always_comb begin
    map_we  = do_copy || do_op;
    map_wa  = do_copy ? owner_a : in_dst;
    map_wt  = do_copy ? cold_tag : victim_tag;
    inc_vec = '0;
    if (do_copy) begin
      inc_vec[victim_tag] = 1'b1;
    end else if (do_op) begin
      inc_vec[s0_tag] = 1'b1;
      inc_vec[s1_tag] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else if (do_copy) begin
      lock_q     <= 1'b1;
      lock_idx_q <= act_idx;
    end else if (do_op) begin
      lock_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      kind_q  <= OUT_OP;
      dst_q   <= '0;
      src0_q  <= '0;
      src1_q  <= '0;
      slot_q  <= '0;
    end else begin
      valid_q <= do_copy || do_op;
      if (do_copy) begin
        kind_q <= OUT_COPY;
        dst_q  <= cold_tag;
        src0_q <= victim_tag;
        src1_q <= victim_tag;
        slot_q <= slot_idx;
      end else if (do_op) begin
        kind_q <= OUT_OP;
        dst_q  <= victim_tag;
        src0_q <= s0_tag;
        src1_q <= s1_tag;
        slot_q <= '0;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_is_copy  = (kind_q == OUT_COPY);
  assign out_dst_tag  = dst_q;
  assign out_src0_tag = src0_q;
  assign out_src1_tag = src1_q;
  assign out_slot     = slot_q;
endmodule

// File: rtl/rn_fu_rename_chk.sv
module rn_fu_rename_chk #(
  parameter int NU    = 6,
  parameter int TAG_W = 4,
  parameter int NSLOT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_is_copy,
  input logic [TAG_W-1:0] out_dst_tag,
  input logic [NSLOT-1:0] slot_busy
);
  // R2
  accept_emits_op_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && !out_is_copy);

  // R2
  op_dst_is_unit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_copy |-> out_dst_tag < TAG_W'(NU));

  // R5
  copy_dst_is_cold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_copy |-> out_dst_tag >= TAG_W'(NU));

  // R5
  copy_only_for_held_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_copy |-> $past(in_valid && !in_ready));

  // R7
  hold_after_copy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_copy |-> !in_ready);

  // R8
  copy_needs_slot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_copy |-> $past(~slot_busy != '0));
endmodule

bind rn_fu_rename rn_fu_rename_chk #(.NU(NU), .TAG_W(TAG_W), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_is_copy(out_is_copy),
  .out_dst_tag(out_dst_tag), .slot_busy(slot_busy)
);

// File: tb/tb_rn_fu_rename.sv
`timescale 1ns/100ps
module tb_rn_fu_rename;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [0:0]  in_cls = '0;
  logic [2:0]  in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic        unit_done_valid = 1'b0;
  logic [2:0]  unit_done_idx = '0;
  logic        copy_done_valid = 1'b0;
  logic [0:0]  copy_done_slot = '0;
  logic [13:0] rd_release = '0;
  logic        out_valid, out_is_copy;
  logic [3:0]  out_dst_tag, out_src0_tag, out_src1_tag;
  logic [0:0]  out_slot;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    bit    cp;
    int    d, s0, s1, sl;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  rn_fu_rename dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src0(in_src0), .in_src1(in_src1),
    .unit_done_valid(unit_done_valid), .unit_done_idx(unit_done_idx),
    .copy_done_valid(copy_done_valid), .copy_done_slot(copy_done_slot),
    .rd_release(rd_release),
    .out_valid(out_valid), .out_is_copy(out_is_copy), .out_dst_tag(out_dst_tag),
    .out_src0_tag(out_src0_tag), .out_src1_tag(out_src1_tag), .out_slot(out_slot)
  );

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected output: got cp=%0d dst=%0d src=%0d,%0d slot=%0d, expected none",
                 out_is_copy, out_dst_tag, out_src0_tag, out_src1_tag, out_slot);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_is_copy != e.cp || int'(out_dst_tag) != e.d || int'(out_src0_tag) != e.s0 ||
            int'(out_src1_tag) != e.s1 || int'(out_slot) != e.sl) begin
          n_bad++;
          $display("FAIL %s: got cp=%0d dst=%0d src=%0d,%0d slot=%0d, expected cp=%0d dst=%0d src=%0d,%0d slot=%0d",
                   e.req, out_is_copy, out_dst_tag, out_src0_tag, out_src1_tag, out_slot,
                   e.cp, e.d, e.s0, e.s1, e.sl);
        end
      end
    end
  end

  task automatic push(input bit cp, input int d, input int s0, input int s1,
                      input int sl, input string req);
    exp_t e;
    e.cp = cp; e.d = d; e.s0 = s0; e.s1 = s1; e.sl = sl; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic chk_ready(input bit expv, input string req);
    n_cmp++;
    if (in_ready !== expv) begin
      n_bad++;
      $display("FAIL %s: in_ready got %0b expected %0b", req, in_ready, expv);
    end
  endtask

  // drives one micro-op and waits for acceptance
  task automatic send(input int cls, input int dst, input int s0, input int s1,
                      input string first_req = "");
    bit r;
    bit first = 1;
    @(negedge clk);
    in_cls = 1'(cls); in_dst = 3'(dst); in_src0 = 3'(s0); in_src1 = 3'(s1);
    in_valid = 1'b1;
    do begin
      #1;
      if (first && first_req != "") chk_ready(1'b1, first_req);
      first = 0;
      r = in_ready;
      @(posedge clk);
      if (!r) @(negedge clk);
    end while (!r);
    #1 in_valid = 1'b0;
  endtask

  task automatic done_unit(input int u);
    @(negedge clk);
    unit_done_valid = 1'b1; unit_done_idx = 3'(u);
    @(negedge clk);
    unit_done_valid = 1'b0;
  endtask

  task automatic copy_done(input int s);
    @(negedge clk);
    copy_done_valid = 1'b1; copy_done_slot = 1'(s);
    @(negedge clk);
    copy_done_valid = 1'b0;
  endtask

  task automatic release_tag(input int t);
    @(negedge clk);
    rd_release[t] = 1'b1;
    @(negedge clk);
    rd_release[t] = 1'b0;
  endtask

  task automatic release_all();
    @(negedge clk);
    rd_release = '1;
    repeat (8) @(negedge clk);
    rd_release = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      foreach (exp_q[i]) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s: expected output never seen (dst=%0d)", exp_q[i].req, exp_q[i].d);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: out_valid got %0b expected 0", out_valid);
    end

    // R1/R3: reset mapping to cold entries, lowest free unit
    push(0, 0, 8, 9, 0, "R1");
    send(0, 1, 2, 3);
    // R10: both sources on one unit
    push(0, 1, 0, 0, 0, "R2");
    send(0, 2, 1, 1);
    push(0, 3, 0, 6, 0, "R2");
    send(1, 4, 1, 0);
    release_tag(8); release_tag(9); release_tag(6);
    push(0, 2, 12, 13, 0, "R1");
    send(0, 5, 6, 7);

    // R4 stall, then R5 copy and R7 hold
    fork
      send(0, 3, 0, 0);
      begin
        repeat (3) @(negedge clk);
        #1 chk_ready(1'b0, "R4");
        push(1, 8, 1, 1, 0, "R5");
        push(0, 1, 6, 6, 0, "R7");
        done_unit(1);
        repeat (3) @(negedge clk);
        #1 chk_ready(1'b0, "R7");
        release_tag(1);
      end
    join

    // R6 no copy when owner is destination only; R10 two releases clear unit 0
    done_unit(0);
    release_tag(0);
    release_tag(0);
    push(0, 0, 1, 3, 0, "R6");
    send(0, 1, 3, 4, "R10");

    // R5 owner is also a source, second slot
    done_unit(2);
    release_all();
    fork
      send(0, 5, 5, 0);
      begin
        push(1, 11, 2, 2, 1, "R5");
        push(0, 2, 11, 6, 0, "R7");
        repeat (4) @(negedge clk);
        release_tag(2);
      end
    join

    // R8 no copy slot free
    done_unit(0);
    release_all();
    fork
      send(0, 6, 0, 0);
      begin
        repeat (4) @(negedge clk);
        #1 chk_ready(1'b0, "R8");
        push(1, 7, 0, 0, 0, "R8");
        push(0, 0, 6, 6, 0, "R8");
        copy_done(0);
        repeat (4) @(negedge clk);
        release_tag(0);
      end
    join

    // R3 lowest free in class 1, then R9 fewest pending readers
    release_all();
    push(0, 4, 3, 3, 0, "R3");
    send(1, 0, 4, 4);
    push(0, 5, 4, 4, 0, "R3");
    send(1, 7, 0, 0);
    copy_done(1);
    done_unit(3);
    done_unit(4);
    done_unit(5);
    fork
      send(1, 2, 1, 1);
      begin
        push(1, 13, 5, 5, 1, "R9");
        push(0, 5, 7, 7, 0, "R9");
        repeat (4) @(negedge clk);
        release_tag(5);
      end
    join

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule